// File: doc/BRIEF.md
# Link Transmitter Configuration Slave (Two-Wire Bus)

This block is the configuration front end of a serial link transmitter. It sits on a two-wire, open-drain control bus (SCL clock, SDA data) as a slave and keeps three byte-wide configuration registers. The first holds an override enable, a sleep request, an output-level choice and a colour-map choice. The second holds the address-source choice and a programmable slave address. The third holds a de-emphasis step code and a de-emphasis disable bit. Both bus lines are brought into the system clock domain through two-flop synchronizers. START and STOP conditions, and the SCL edges, are found from the synchronized samples.

The block also produces the effective configuration. While the override bit is clear, the map and level selections come from the strap inputs, sleep is off and the de-emphasis outputs are zero, so the external setting applies. While the override bit is set, all of these come from the registers. The slave address never follows the override bit. It comes from the 2-bit strap code unless the address-source bit is set, in which case the programmed address is used. A power-down input returns every register to its default. Sleep leaves every register as it is.

Top module: `lnk_cfg_i2c_slave`

## Requirements
- R1: After reset, register 0 reads 0x00, register 1 reads 0x68 and register 2 reads 0x00, SDA is released, and the outputs follow the straps with sleep, de-emphasis code and de-emphasis disable all 0.
- R2: An address byte whose upper seven bits (bit 0 is read=1/write=0) equal the active slave address gets an ACK (SDA driven low in the ninth clock). Any other address gets no ACK, SDA stays released and the registers do not change.
- R3: While register 1 bit 7 is 0, the slave address comes from the strap code: 00 gives 0x69, 01 gives 0x6A, 10 gives 0x6B and 11 gives 0x6E.
- R4: While register 1 bit 7 is 1, the slave address is register 1 bits 6:0. Register 0 bit 0 has no effect on the address. A transaction that changes the address keeps being acknowledged until its STOP.
- R5: In a write, the first byte after the address loads the register pointer. Each later byte is written to the register at the pointer, and the pointer then increments. Every written byte is acknowledged.
- R6: In a read, bytes come MSB first starting at the pointer, and the pointer increments after each byte. A master ACK continues the read. A master NACK ends it with SDA released.
- R7: Pointers 3 and above read as 0x00. Writes to them are acknowledged and change no register.
- R8: With register 0 bit 0 set to 1, map select is register 0 bit 6, output-level select is bit 5, sleep is bit 1, the de-emphasis code is register 2 bits 7:5 and de-emphasis disable is register 2 bit 4. With bit 0 at 0, map and level follow the straps and the other three outputs are 0.
- R9: A power-down pulse returns all registers to their reset values. Setting sleep keeps all register contents.
- R10: The slave changes its SDA drive only while synchronized SCL is low.
- R11: A STOP releases SDA and abandons a partly received byte without writing it. A START or repeated START begins a new address phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| addr_strap_i | input | 2 | Strap code selecting the default slave address |
| strap_map_i | input | 1 | Strap value for colour-map select |
| strap_lvl_i | input | 1 | Strap value for output-level select |
| pwrdn_i | input | 1 | Power-down: registers return to defaults, bus released |
| map_sel_o | output | 1 | Effective colour-map select |
| lvl_sel_o | output | 1 | Effective output-level select |
| sleep_o | output | 1 | Effective sleep request |
| deemph_code_o | output | 3 | Effective de-emphasis step code (0 = external) |
| deemph_off_o | output | 1 | Effective de-emphasis disable |

## Verification
The ACK of a data byte and an address change can fall in the same cycle. This happens when a burst writes register 1 with the address-source bit set: the new address takes effect on the same SCL fall that starts the ACK of that byte. The bench writes register 1 and then register 2 in one burst under the strap address. It judges the case by the ACK of the second byte, by the new de-emphasis outputs, and by a following read that the programmed address answers while the strap address gets no ACK.

// File: rtl/lnk_cfg_pkg.sv
package lnk_cfg_pkg;

  localparam int unsigned BYTE_W = 8;
  localparam int unsigned DEV_W  = 7;

  // register 0 fields
  localparam int unsigned R0_OVR   = 0;
  localparam int unsigned R0_SLEEP = 1;
  localparam int unsigned R0_LVL   = 5;
  localparam int unsigned R0_MAP   = 6;
  // register 1 fields
  localparam int unsigned R1_SRC   = 7;
  // register 2 fields
  localparam int unsigned R2_OFF   = 4;
  localparam int unsigned R2_CODE  = 5;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_WDATA,
    ST_WACK,
    ST_RDATA,
    ST_RACK
  } bus_state_e;

  function automatic logic [BYTE_W-1:0] reg_default(input int unsigned idx);
    case (idx)
      1:       reg_default = 8'h68;
      default: reg_default = 8'h00;
    endcase
  endfunction

  function automatic logic [DEV_W-1:0] strap_address(input logic [1:0] code);
    case (code)
      2'b00:   strap_address = 7'h69;
      2'b01:   strap_address = 7'h6A;
      2'b10:   strap_address = 7'h6B;
      default: strap_address = 7'h6E;
    endcase
  endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);

  logic [STAGES-1:0] scl_ff_q, scl_ff_d;
  logic [STAGES-1:0] sda_ff_q, sda_ff_d;
  logic              scl_prev_q, sda_prev_q;

  generate
    if (STAGES == 1) begin : g_one
      always_comb begin
        scl_ff_d = scl_i;
        sda_ff_d = sda_i;
      end
    end else begin : g_chain
      always_comb begin
        scl_ff_d = {scl_ff_q[STAGES-2:0], scl_i};
        sda_ff_d = {sda_ff_q[STAGES-2:0], sda_i};
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff_q   <= '1;
      sda_ff_q   <= '1;
      scl_prev_q <= 1'b1;
      sda_prev_q <= 1'b1;
    end else begin
      scl_ff_q   <= scl_ff_d;
      sda_ff_q   <= sda_ff_d;
      scl_prev_q <= scl_ff_q[STAGES-1];
      sda_prev_q <= sda_ff_q[STAGES-1];
    end
  end

  assign scl_o      = scl_ff_q[STAGES-1];
  assign sda_o      = sda_ff_q[STAGES-1];
  assign scl_rise_o = scl_o & ~scl_prev_q;
  assign scl_fall_o = ~scl_o & scl_prev_q;
  assign start_o    = scl_o & scl_prev_q & sda_prev_q & ~sda_o;
  assign stop_o     = scl_o & scl_prev_q & ~sda_prev_q & sda_o;

endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank
  import lnk_cfg_pkg::*;
#(
  parameter int unsigned NUM_REGS = 3,
  parameter int unsigned PTR_W    = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pwrdn_i,
  input  logic              wr_en_i,
  input  logic [PTR_W-1:0]  wr_ptr_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic [PTR_W-1:0]  rd_ptr_i,
  output logic [BYTE_W-1:0] rd_data_o,
  input  logic [1:0]        addr_strap_i,
  input  logic              strap_map_i,
  input  logic              strap_lvl_i,
  output logic [DEV_W-1:0]  dev_addr_o,
  output logic              map_sel_o,
  output logic              lvl_sel_o,
  output logic              sleep_o,
  output logic [2:0]        deemph_code_o,
  output logic              deemph_off_o
);

  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(NUM_REGS - 1);

  logic [NUM_REGS-1:0][BYTE_W-1:0] regs_q, regs_d;
  logic                            regs_en;
  logic                            ovr;

  always_comb begin
    regs_d  = regs_q;
    regs_en = 1'b0;
    if (pwrdn_i) begin
      regs_en = 1'b1;
      for (int i = 0; i < NUM_REGS; i++) regs_d[i] = reg_default(i);
    end else if (wr_en_i && (wr_ptr_i <= LAST_PTR)) begin
      regs_en = 1'b1;
      for (int i = 0; i < NUM_REGS; i++)
        if (wr_ptr_i == PTR_W'(i)) regs_d[i] = wr_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_REGS; i++) regs_q[i] <= reg_default(i);
    end else if (regs_en) begin
      regs_q <= regs_d;
    end
  end

  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (rd_ptr_i == PTR_W'(i)) rd_data_o = regs_q[i];
  end

  assign ovr           = regs_q[0][R0_OVR];
  assign map_sel_o     = ovr ? regs_q[0][R0_MAP]   : strap_map_i;
  assign lvl_sel_o     = ovr ? regs_q[0][R0_LVL]   : strap_lvl_i;
  assign sleep_o       = ovr & regs_q[0][R0_SLEEP];
  assign deemph_code_o = ovr ? regs_q[2][R2_CODE +: 3] : 3'b000;
  assign deemph_off_o  = ovr & regs_q[2][R2_OFF];
  assign dev_addr_o    = regs_q[1][R1_SRC] ? regs_q[1][DEV_W-1:0]
                                           : strap_address(addr_strap_i);

  assert_pwrdn_defaults_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwrdn_i |=> (rd_ptr_i != 8'd0 || rd_data_o == 8'h00) && dev_addr_o == strap_address(addr_strap_i)
                && !sleep_o && !deemph_off_o);

  assert_oob_write_ignored_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_ptr_i > LAST_PTR && !pwrdn_i) |=> $stable(regs_q));

  assert_override_outputs_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_ptr_i == '0 && wr_data_i[R0_OVR] && !pwrdn_i) |=>
      (map_sel_o == $past(wr_data_i[R0_MAP]) && lvl_sel_o == $past(wr_data_i[R0_LVL])
       && sleep_o == $past(wr_data_i[R0_SLEEP])));

  assert_reg_address_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_ptr_i == PTR_W'(1) && wr_data_i[R1_SRC] && !pwrdn_i) |=>
      dev_addr_o == $past(wr_data_i[DEV_W-1:0]));

endmodule

// File: rtl/i2c_slave_fsm.sv
module i2c_slave_fsm
  import lnk_cfg_pkg::*;
#(
  parameter int unsigned PTR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pwrdn_i,
  input  logic              scl_s_i,
  input  logic              sda_s_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [DEV_W-1:0]  dev_addr_i,
  input  logic [BYTE_W-1:0] rd_data_i,
  output logic              sda_oe_o,
  output logic [PTR_W-1:0]  ptr_o,
  output logic              wr_en_o,
  output logic [BYTE_W-1:0] wr_data_o
);

  localparam int unsigned CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  bus_state_e        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BYTE_W-1:0] sh_q, sh_d;
  logic [PTR_W-1:0]  ptr_q, ptr_d;
  logic              ack_q, ack_d;
  logic              pend_q, pend_d;
  logic              cont_q, cont_d;
  logic              last_q, last_d;
  logic              oe_q, oe_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    sh_d    = sh_q;
    ptr_d   = ptr_q;
    ack_d   = ack_q;
    pend_d  = pend_q;
    cont_d  = cont_q;
    last_d  = last_q;
    oe_d    = oe_q;
    wr_en_o = 1'b0;
    if (pwrdn_i) begin
      state_d = ST_IDLE;
      oe_d    = 1'b0;
      ptr_d   = '0;
      ack_d   = 1'b0;
      last_d  = 1'b0;
    end else if (start_i) begin
      state_d = ST_ADDR;
      cnt_d   = '0;
      oe_d    = 1'b0;
      ack_d   = 1'b0;
      last_d  = 1'b0;
    end else if (stop_i) begin
      state_d = ST_IDLE;
      oe_d    = 1'b0;
    end else begin
      case (state_q)
        ST_ADDR: if (scl_rise_i) begin
          sh_d  = {sh_q[BYTE_W-2:0], sda_s_i};
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == LAST_BIT) state_d = ST_AACK;
        end
        ST_AACK: if (scl_fall_i) begin
          if (!ack_q) begin
            if (sh_q[BYTE_W-1:1] == dev_addr_i) begin
              ack_d = 1'b1;
              oe_d  = 1'b1;
            end else begin
              state_d = ST_IDLE;
            end
          end else begin
            ack_d = 1'b0;
            cnt_d = '0;
            if (sh_q[0]) begin
              sh_d    = rd_data_i;
              oe_d    = ~rd_data_i[BYTE_W-1];
              state_d = ST_RDATA;
            end else begin
              oe_d    = 1'b0;
              pend_d  = 1'b1;
              state_d = ST_WDATA;
            end
          end
        end
        ST_WDATA: if (scl_rise_i) begin
          sh_d  = {sh_q[BYTE_W-2:0], sda_s_i};
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == LAST_BIT) state_d = ST_WACK;
        end
        ST_WACK: if (scl_fall_i) begin
          if (!ack_q) begin
            ack_d = 1'b1;
            oe_d  = 1'b1;
            if (pend_q) begin
              ptr_d  = sh_q;
              pend_d = 1'b0;
            end else begin
              wr_en_o = 1'b1;
              ptr_d   = ptr_q + 1'b1;
            end
          end else begin
            ack_d   = 1'b0;
            oe_d    = 1'b0;
            cnt_d   = '0;
            state_d = ST_WDATA;
          end
        end
        ST_RDATA: begin
          if (scl_rise_i) begin
            cnt_d = cnt_q + 1'b1;
            if (cnt_q == LAST_BIT) last_d = 1'b1;
          end else if (scl_fall_i) begin
            if (last_q) begin
              last_d  = 1'b0;
              oe_d    = 1'b0;
              ptr_d   = ptr_q + 1'b1;
              state_d = ST_RACK;
            end else begin
              sh_d = {sh_q[BYTE_W-2:0], 1'b0};
              oe_d = ~sh_q[BYTE_W-2];
            end
          end
        end
        ST_RACK: begin
          if (scl_rise_i) begin
            cont_d = ~sda_s_i;
          end else if (scl_fall_i) begin
            if (cont_q) begin
              sh_d    = rd_data_i;
              oe_d    = ~rd_data_i[BYTE_W-1];
              cnt_d   = '0;
              state_d = ST_RDATA;
            end else begin
              state_d = ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      ptr_q   <= '0;
      ack_q   <= 1'b0;
      pend_q  <= 1'b0;
      cont_q  <= 1'b0;
      last_q  <= 1'b0;
      oe_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      ptr_q   <= ptr_d;
      ack_q   <= ack_d;
      pend_q  <= pend_d;
      cont_q  <= cont_d;
      last_q  <= last_d;
      oe_q    <= oe_d;
    end
  end

  assign sda_oe_o  = oe_q;
  assign ptr_o     = ptr_q;
  assign wr_data_o = sh_q;

  assert_sda_moves_scl_low_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(sda_oe_o) && !$past(pwrdn_i)) |-> !scl_s_i);

  assert_stop_releases_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !sda_oe_o);

  assert_start_new_address_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !pwrdn_i) |=> (state_q == ST_ADDR && cnt_q == '0));

  assert_nack_foreign_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_AACK && scl_fall_i && !ack_q && !start_i && !stop_i && !pwrdn_i
     && sh_q[BYTE_W-1:1] != dev_addr_i) |=> (!sda_oe_o && state_q == ST_IDLE));

endmodule

// File: rtl/lnk_cfg_i2c_slave.sv
module lnk_cfg_i2c_slave
  import lnk_cfg_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned NUM_REGS    = 3,
  parameter int unsigned PTR_W       = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe_o,
  input  logic [1:0] addr_strap_i,
  input  logic       strap_map_i,
  input  logic       strap_lvl_i,
  input  logic       pwrdn_i,
  output logic       map_sel_o,
  output logic       lvl_sel_o,
  output logic       sleep_o,
  output logic [2:0] deemph_code_o,
  output logic       deemph_off_o
);

  logic              scl_s, sda_s, scl_rise, scl_fall, bus_start, bus_stop;
  logic [DEV_W-1:0]  dev_addr;
  logic [BYTE_W-1:0] rd_data, wr_data;
  logic [PTR_W-1:0]  ptr;
  logic              wr_en;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_o      (scl_s),
    .sda_o      (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (bus_start),
    .stop_o     (bus_stop)
  );

  i2c_slave_fsm #(.PTR_W(PTR_W)) fsm_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pwrdn_i    (pwrdn_i),
    .scl_s_i    (scl_s),
    .sda_s_i    (sda_s),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .start_i    (bus_start),
    .stop_i     (bus_stop),
    .dev_addr_i (dev_addr),
    .rd_data_i  (rd_data),
    .sda_oe_o   (sda_oe_o),
    .ptr_o      (ptr),
    .wr_en_o    (wr_en),
    .wr_data_o  (wr_data)
  );

  cfg_reg_bank #(.NUM_REGS(NUM_REGS), .PTR_W(PTR_W)) regs_i (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .pwrdn_i       (pwrdn_i),
    .wr_en_i       (wr_en),
    .wr_ptr_i      (ptr),
    .wr_data_i     (wr_data),
    .rd_ptr_i      (ptr),
    .rd_data_o     (rd_data),
    .addr_strap_i  (addr_strap_i),
    .strap_map_i   (strap_map_i),
    .strap_lvl_i   (strap_lvl_i),
    .dev_addr_o    (dev_addr),
    .map_sel_o     (map_sel_o),
    .lvl_sel_o     (lvl_sel_o),
    .sleep_o       (sleep_o),
    .deemph_code_o (deemph_code_o),
    .deemph_off_o  (deemph_off_o)
  );

endmodule

// File: tb/lnk_cfg_i2c_slave_tb_top.sv
module lnk_cfg_i2c_slave_tb_top;

  localparam int Q = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl = 1'b1;
  logic       m_low = 1'b0;
  logic [1:0] strap = 2'b00;
  logic       s_map = 1'b1;
  logic       s_lvl = 1'b1;
  logic       pwrdn = 1'b0;
  logic       sda_oe, map_sel, lvl_sel, sleep, dm_off;
  logic [2:0] dm_code;
  logic       sda_line;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [7:0] rd_buf [4];

  string exp_tag_q[$];
  int    exp_q[$];
  int    act_q[$];

  always #5 clk = ~clk;

  assign sda_line = ~(m_low | sda_oe);

  lnk_cfg_i2c_slave dut_i (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe_o(sda_oe),
    .addr_strap_i(strap), .strap_map_i(s_map), .strap_lvl_i(s_lvl), .pwrdn_i(pwrdn),
    .map_sel_o(map_sel), .lvl_sel_o(lvl_sel), .sleep_o(sleep),
    .deemph_code_o(dm_code), .deemph_off_o(dm_off)
  );

  // scoreboard monitor: pops expected/observed pairs and compares them
  initial begin
    forever begin
      @(posedge clk);
      while (act_q.size() > 0 && exp_q.size() > 0) begin
        automatic string t = exp_tag_q.pop_front();
        automatic int    e = exp_q.pop_front();
        automatic int    a = act_q.pop_front();
        checks++;
        if (a !== e) begin
          errors++;
          $display("FAIL %s actual 0x%0h expected 0x%0h", t, a, e);
        end
      end
    end
  end

  task automatic push(input string tag, input int e, input int a);
    exp_tag_q.push_back(tag);
    exp_q.push_back(e);
    act_q.push_back(a);
  endtask

  task automatic qw();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    m_low = 1'b0; qw();
    scl = 1'b1; qw();
    m_low = 1'b1; qw();
    scl = 1'b0; qw();
  endtask

  task automatic bus_stop();
    m_low = 1'b1; qw();
    scl = 1'b1; qw();
    m_low = 1'b0; qw();
  endtask

  task automatic send_bit(input logic b);
    m_low = ~b; qw();
    scl = 1'b1; qw(); qw();
    scl = 1'b0; qw();
  endtask

  task automatic recv_bit(output logic b);
    m_low = 1'b0; qw();
    scl = 1'b1; qw();
    b = sda_line; qw();
    scl = 1'b0; qw();
  endtask

  task automatic write_byte(input logic [7:0] d, output logic ack_lvl);
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    recv_bit(ack_lvl);
  endtask

  task automatic read_byte(output logic [7:0] d, input logic more);
    for (int i = 7; i >= 0; i--) recv_bit(d[i]);
    send_bit(~more);
  endtask

  task automatic wr_seq(input logic [6:0] dev, input logic [7:0] ptr, input int n,
                        input logic [7:0] d0, input logic [7:0] d1, input string tag);
    logic a;
    bus_start();
    write_byte({dev, 1'b0}, a); push({tag, " addr ack"}, 0, a);
    write_byte(ptr, a);         push({tag, " pointer ack"}, 0, a);
    if (n > 0) begin write_byte(d0, a); push({tag, " data0 ack"}, 0, a); end
    if (n > 1) begin write_byte(d1, a); push({tag, " data1 ack"}, 0, a); end
    bus_stop();
  endtask

  task automatic rd_seq(input logic [6:0] dev, input logic [7:0] ptr, input int n);
    logic a;
    bus_start();
    write_byte({dev, 1'b0}, a); push("R2 read setup ack", 0, a);
    write_byte(ptr, a);         push("R5 read pointer ack", 0, a);
    bus_start();
    write_byte({dev, 1'b1}, a); push("R11 repeated start addr ack", 0, a);
    for (int i = 0; i < n; i++) read_byte(rd_buf[i], i < n - 1);
    bus_stop();
    push("R6 SDA released after NACK", 0, sda_oe);
  endtask

  task automatic probe(input logic [6:0] dev, input int exp_ack, input string tag);
    logic a;
    bus_start();
    write_byte({dev, 1'b0}, a);
    push(tag, exp_ack, a);
    bus_stop();
  endtask

  task automatic check_outs(input int m, input int l, input int s, input int c, input int o,
                            input string tag);
    repeat (4) @(negedge clk);
    push({tag, " map"}, m, map_sel);
    push({tag, " lvl"}, l, lvl_sel);
    push({tag, " sleep"}, s, sleep);
    push({tag, " code"}, c, dm_code);
    push({tag, " off"}, o, dm_off);
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    automatic int strap_tbl[4] = '{'h69, 'h6A, 'h6B, 'h6E};
    logic a;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1: reset state, outputs follow straps
    push("R1 sda released", 0, sda_oe);
    check_outs(1, 1, 0, 0, 0, "R1 reset");
    s_map = 1'b0; s_lvl = 1'b0;
    check_outs(0, 0, 0, 0, 0, "R8 strap follow");
    rd_seq(7'h69, 8'd0, 3);
    push("R1 reg0 default", 'h00, rd_buf[0]);
    push("R1 reg1 default", 'h68, rd_buf[1]);
    push("R1 reg2 default", 'h00, rd_buf[2]);

    // R2: foreign address is not acknowledged
    probe(7'h6A, 1, "R2 foreign address NACK");
    push("R2 SDA idle after NACK", 0, sda_oe);

    // R5/R8: override writes
    wr_seq(7'h69, 8'd0, 1, 8'h61, 8'h00, "R5 reg0 write");
    check_outs(1, 1, 0, 0, 0, "R8 override reg0");
    wr_seq(7'h69, 8'd2, 1, 8'hB0, 8'h00, "R5 reg2 write");
    check_outs(1, 1, 0, 5, 1, "R8 override reg2");

    // R6/R7: burst read over the end of the map
    rd_seq(7'h69, 8'd0, 4);
    push("R6 burst byte0", 'h61, rd_buf[0]);
    push("R6 burst byte1", 'h68, rd_buf[1]);
    push("R6 burst byte2", 'hB0, rd_buf[2]);
    push("R7 byte past map", 'h00, rd_buf[3]);

    // R7: writes past the map are acked and ignored
    wr_seq(7'h69, 8'd3, 2, 8'hFF, 8'hFF, "R7 out-of-range write");
    rd_seq(7'h69, 8'd0, 3);
    push("R7 reg0 intact", 'h61, rd_buf[0]);
    push("R7 reg1 intact", 'h68, rd_buf[1]);
    push("R7 reg2 intact", 'hB0, rd_buf[2]);

    // R3: strap address table
    for (int c = 0; c < 4; c++) begin
      strap = 2'(c);
      repeat (4) @(negedge clk);
      probe(7'(strap_tbl[c]), 0, "R3 strap address ACK");
      probe(7'(strap_tbl[(c + 1) % 4]), 1, "R3 other strap address NACK");
    end
    strap = 2'b00;

    // R4: address change and next byte ack in the same burst
    wr_seq(7'h69, 8'd1, 2, 8'hD5, 8'h20, "R4 burst across address change");
    check_outs(1, 1, 0, 1, 0, "R4 reg2 written after change");
    probe(7'h69, 1, "R4 strap address now NACK");
    rd_seq(7'h55, 8'd0, 3);
    push("R4 reg0 via new address", 'h61, rd_buf[0]);
    push("R4 reg1 via new address", 'hD5, rd_buf[1]);
    push("R4 reg2 via new address", 'h20, rd_buf[2]);

    // R8/R4: override off, address unaffected
    wr_seq(7'h55, 8'd0, 1, 8'h60, 8'h00, "R4 clear override");
    check_outs(0, 0, 0, 0, 0, "R8 override off");
    s_map = 1'b1;
    check_outs(1, 0, 0, 0, 0, "R8 strap follow again");
    s_map = 1'b0;
    rd_seq(7'h55, 8'd0, 1);
    push("R4 address kept without override", 'h60, rd_buf[0]);

    // R11: STOP in the middle of a data byte
    bus_start();
    write_byte({7'h55, 1'b0}, a); push("R11 addr ack", 0, a);
    write_byte(8'h00, a);          push("R11 pointer ack", 0, a);
    for (int i = 0; i < 4; i++) send_bit(1'b1);
    bus_stop();
    push("R11 SDA released after STOP", 0, sda_oe);
    rd_seq(7'h55, 8'd0, 1);
    push("R11 partial byte dropped", 'h60, rd_buf[0]);

    // R9: sleep keeps contents
    wr_seq(7'h55, 8'd0, 1, 8'h03, 8'h00, "R9 sleep write");
    check_outs(0, 0, 1, 1, 0, "R9 sleep asserted");
    rd_seq(7'h55, 8'd0, 3);
    push("R9 reg0 retained", 'h03, rd_buf[0]);
    push("R9 reg1 retained", 'hD5, rd_buf[1]);
    push("R9 reg2 retained", 'h20, rd_buf[2]);

    // R9: power-down restores defaults
    @(negedge clk); pwrdn = 1'b1;
    repeat (3) @(negedge clk); pwrdn = 1'b0;
    check_outs(0, 0, 0, 0, 0, "R9 after power-down");
    probe(7'h55, 1, "R9 programmed address gone");
    rd_seq(7'h69, 8'd0, 3);
    push("R9 reg0 default", 'h00, rd_buf[0]);
    push("R9 reg1 default", 'h68, rd_buf[1]);
    push("R9 reg2 default", 'h00, rd_buf[2]);
    push("R10 SDA idle at end", 0, sda_oe);

    repeat (4) @(posedge clk);
    wait (act_q.size() == 0);
    @(negedge clk);
    done = 1'b1;
    summary();
    $finish;
  end

endmodule